// File: doc/BRIEF.md
# Memory Test Pattern Generator and Checker

This block produces the data word for every write beat of a memory test and checks every beat returned during a read pass. One of four fill patterns is chosen when an operation starts: constant zeros, constant ones, a counting pattern, or a word supplied by the caller. An external sequencer pulses `start_i` at the start of each pass. It then strobes `wr_beat_i` each time the memory accepts the word on `wr_data_o`, and raises `rd_valid_i` with `rd_data_i` each time a word comes back.

During reads the block regenerates the same sequence on its own. It compares each returned word with the expected word and counts the differences in a saturating counter. It also holds a copy of the most recent returned word. Addressing and bus protocol belong to the sequencer.

Top module: `mempat_engine`

## Requirements
- R1: After reset, `wr_data_o`, `err_count_o` and `last_rd_o` are all zero.
- R2: At a start pulse the fill mode is taken from `mode_i`. Bit 0 selects zeros, bit 1 ones, bit 2 counting and bit 3 the user word. When several bits are set, the lowest set bit decides. When no bit is set, the mode is zeros.
- R3: In zeros mode every word is 0x00000000. In ones mode every word is 0xFFFFFFFF. In user mode every word equals the `user_word_i` value captured at the start pulse.
- R4: In counting mode, byte b (bit field 8b+7:8b) of word n carries the value v = (4n+b) mod 16 in both nibbles. The words run 0x33221100, 0x77665544, 0xBBAA9988, 0xFFEEDDCC and then repeat. The count begins at word 0 at every start pulse.
- R5: The write word steps only on a cycle with `wr_beat_i` high and `start_i` low. The next word appears on `wr_data_o` in the cycle after that edge. Otherwise it holds.
- R6: Each `rd_valid_i` beat (with `start_i` low) whose data differs from the expected word adds one to `err_count_o`. The expected sequence steps only on such beats and follows the same rules as the write sequence.
- R7: `last_rd_o` takes `rd_data_i` on every accepted read beat and holds otherwise.
- R8: A start pulse clears the error count and the last-read word, and restarts both sequences. Beats that arrive in the start cycle are ignored. Changes to `mode_i` and `user_word_i` have no effect until the next start pulse.
- R9: The error count saturates at its maximum value (all ones in ERR_W bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new operation; captures mode and user word |
| mode_i | input | 4 | Fill mode selection bits |
| user_word_i | input | 32 | Word used in user mode |
| wr_beat_i | input | 1 | Current write word accepted; advance |
| wr_data_o | output | 32 | Write data for the next beat |
| rd_valid_i | input | 1 | A read beat is present on rd_data_i |
| rd_data_i | input | 32 | Returned read data |
| err_count_o | output | ERR_W | Saturating mismatch count |
| last_rd_o | output | 32 | Most recent read word |

## Verification
A wrong write position or a wrong latched mode appears on `wr_data_o` in the first cycle after the edge that corrupted it, because the output is decoded directly from registered state. A wrong read position is only seen when a beat arrives: the error count then rises on correct data, one cycle after that beat. A faulty clear or saturation shows on `err_count_o` at once. The bench therefore compares every output on every cycle against a model and supplies read data that is correct most of the time.

// File: rtl/mempat_pkg.sv
package mempat_pkg;

    localparam int unsigned MP_DATA_W = 32;
    localparam int unsigned MP_BYTES  = MP_DATA_W / 8;
    localparam int unsigned MP_MODE_W = 4;

    typedef logic [MP_DATA_W-1:0] word_t;
    typedef logic [3:0]           nib_t;

    typedef enum logic [1:0] {
        PAT_ZERO = 2'd0,
        PAT_ONES = 2'd1,
        PAT_INCR = 2'd2,
        PAT_USER = 2'd3
    } pat_e;

    // Step of the nibble base per word, modulo 16
    localparam nib_t MP_NIB_STEP = nib_t'(MP_BYTES);

    // Word for a given mode, user word and nibble base of byte 0
    function automatic word_t pat_word(pat_e m, word_t user, nib_t base);
        word_t w;
        nib_t  v;
        w = '0;
        case (m)
            PAT_ZERO: w = '0;
            PAT_ONES: w = '1;
            PAT_USER: w = user;
            PAT_INCR: begin
                for (int b = 0; b < int'(MP_BYTES); b++) begin
                    v = base + nib_t'(b);
                    w[8*b +: 8] = {v, v};
                end
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mempat_mode_dec.sv
module mempat_mode_dec
    import mempat_pkg::*;
(
    input  logic [MP_MODE_W-1:0] bits_i,
    output pat_e                 mode_o
);

    always_comb begin
        if (bits_i[0])      mode_o = PAT_ZERO;
        else if (bits_i[1]) mode_o = PAT_ONES;
        else if (bits_i[2]) mode_o = PAT_INCR;
        else if (bits_i[3]) mode_o = PAT_USER;
        else                mode_o = PAT_ZERO;
    end

endmodule

// File: rtl/mempat_seq.sv
module mempat_seq
    import mempat_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart_i,
    input  logic  advance_i,
    input  pat_e  mode_i,
    input  word_t user_i,
    output word_t word_o
);

    typedef struct packed {
        nib_t base;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.base = '0;
        end else if (advance_i) begin
            st_d.base = st_q.base + MP_NIB_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = pat_word(mode_i, user_i, st_q.base);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !advance_i) |=> $stable(word_o));

    // R8
    restart_first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (word_o == pat_word(mode_i, user_i, nib_t'(0))));

endmodule

// File: rtl/mempat_check.sv
module mempat_check
    import mempat_pkg::*;
#(
    parameter int unsigned ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             valid_i,
    input  word_t            data_i,
    input  word_t            expect_i,
    output logic [ERR_W-1:0] err_o,
    output word_t            last_o
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;
    localparam logic [ERR_W-1:0] ERR_ONE = ERR_W'(1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        word_t            last;
    } chk_state_t;

    chk_state_t st_d, st_q;
    logic       miss;

    assign miss = (data_i != expect_i);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.err  = '0;
            st_d.last = '0;
        end else if (valid_i) begin
            st_d.last = data_i;
            if (miss && (st_q.err != ERR_MAX)) begin
                st_d.err = st_q.err + ERR_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o  = st_q.err;
    assign last_o = st_q.last;

    // R6
    err_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((err_o == $past(err_o)) || (err_o == $past(err_o) + ERR_ONE)));

    // R9
    err_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && err_o == ERR_MAX) |=> (err_o == ERR_MAX));

    // R7
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !valid_i) |=> $stable(last_o));

endmodule

// File: rtl/mempat_engine.sv
module mempat_engine
    import mempat_pkg::*;
#(
    parameter int unsigned ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       mode_i,
    input  logic [31:0]      user_word_i,
    input  logic             wr_beat_i,
    output logic [31:0]      wr_data_o,
    input  logic             rd_valid_i,
    input  logic [31:0]      rd_data_i,
    output logic [ERR_W-1:0] err_count_o,
    output logic [31:0]      last_rd_o
);

    typedef struct packed {
        pat_e  mode;
        word_t user;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    pat_e       mode_pick;
    word_t      rd_expect;
    logic       wr_adv, rd_adv;

    mempat_mode_dec u_dec (
        .bits_i (mode_i),
        .mode_o (mode_pick)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (start_i) begin
            cfg_d.mode = mode_pick;
            cfg_d.user = user_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: PAT_ZERO, user: '0};
        else        cfg_q <= cfg_d;
    end

    assign wr_adv = wr_beat_i  && !start_i;
    assign rd_adv = rd_valid_i && !start_i;

    mempat_seq u_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .advance_i (wr_adv),
        .mode_i    (cfg_q.mode),
        .user_i    (cfg_q.user),
        .word_o    (wr_data_o)
    );

    mempat_seq u_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .advance_i (rd_adv),
        .mode_i    (cfg_q.mode),
        .user_i    (cfg_q.user),
        .word_o    (rd_expect)
    );

    mempat_check #(.ERR_W(ERR_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .valid_i  (rd_adv),
        .data_i   (rd_data_i),
        .expect_i (rd_expect),
        .err_o    (err_count_o),
        .last_o   (last_rd_o)
    );

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (err_count_o == '0 && last_rd_o == 32'h0));

    // R2
    ones_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i[1:0] == 2'b10) |=> (wr_data_o == 32'hFFFF_FFFF));

    // R2
    zero_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i[0]) |=> (wr_data_o == 32'h0));

endmodule

// File: tb/sim_mempat_engine.sv
module sim_mempat_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [31:0] user_word_i = '0;
    logic        wr_beat_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [31:0] wr_data_o, last_rd_o, err_count_o;
    logic [31:0] wr_data_s, last_rd_s;
    logic [3:0]  err_s;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int unsigned m_mode = 0;
    logic [31:0] m_user = '0;
    int unsigned m_wpos = 0, m_rpos = 0;
    logic [31:0] m_err = '0;
    logic [3:0]  m_err4 = '0;
    logic [31:0] m_last = '0;

    always #4 clk = ~clk;

    mempat_engine #(.ERR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .user_word_i(user_word_i), .wr_beat_i(wr_beat_i), .wr_data_o(wr_data_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .err_count_o(err_count_o), .last_rd_o(last_rd_o)
    );

    mempat_engine #(.ERR_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .user_word_i(user_word_i), .wr_beat_i(wr_beat_i), .wr_data_o(wr_data_s),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .err_count_o(err_s), .last_rd_o(last_rd_s)
    );

    // R2 mode numbering: 0 zeros, 1 ones, 2 counting, 3 user
    function automatic int unsigned pick_mode(logic [3:0] b);
        for (int i = 0; i < 4; i++) if (b[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] model_word(int unsigned md, logic [31:0] u, int unsigned pos);
        logic [31:0] w;
        int unsigned v;
        case (md)
            1: w = 32'hFFFF_FFFF;
            2: begin
                for (int b = 0; b < 4; b++) begin
                    v = (4 * pos + b) % 16;
                    w[8*b +: 8] = 8'(v * 17);
                end
            end
            3: w = u;
            default: w = 32'h0;
        endcase
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update model, compare after the edge
    task automatic tick(bit st, logic [3:0] md, logic [31:0] uw, bit wb, bit rv, logic [31:0] rd);
        start_i = st; mode_i = md; user_word_i = uw;
        wr_beat_i = wb; rd_valid_i = rv; rd_data_i = rd;
        @(posedge clk);
        #1;
        if (st) begin
            m_mode = pick_mode(md); m_user = uw;
            m_wpos = 0; m_rpos = 0; m_err = 0; m_err4 = 0; m_last = 0;
        end else begin
            if (rv) begin
                if (rd != model_word(m_mode, m_user, m_rpos)) begin
                    if (m_err != 32'hFFFF_FFFF) m_err++;
                    if (m_err4 != 4'hF) m_err4++;
                end
                m_last = rd;
                m_rpos++;
            end
            if (wb) m_wpos++;
        end
        chk("R5 write word", wr_data_o, model_word(m_mode, m_user, m_wpos));
        chk("R6 error count", err_count_o, m_err);
        chk("R7 last read", last_rd_o, m_last);
        chk("R9 narrow count", {28'h0, err_s}, {28'h0, m_err4});
    endtask

    task automatic idle();
        tick(0, mode_i, user_word_i, 0, 0, rd_data_i);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_rd;
        void'($urandom(32'd7781));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset wr_data", wr_data_o, 32'h0);
        chk("R1 reset err", err_count_o, 32'h0);
        chk("R1 reset last", last_rd_o, 32'h0);
        rst_n = 1'b1;
        idle();

        // R4 counting sequence
        tick(1, 4'b0100, 32'h0, 0, 0, 0);
        chk("R4 word0", wr_data_o, 32'h3322_1100);
        tick(0, 4'b0001, 32'h0, 1, 0, 0);
        chk("R4 word1", wr_data_o, 32'h7766_5544);
        idle();
        chk("R5 hold", wr_data_o, 32'h7766_5544);
        tick(0, 4'b0001, 32'h0, 1, 0, 0);
        chk("R4 word2", wr_data_o, 32'hBBAA_9988);
        tick(0, 4'b0001, 32'h0, 1, 0, 0);
        chk("R4 word3", wr_data_o, 32'hFFEE_DDCC);
        tick(0, 4'b0001, 32'h0, 1, 0, 0);
        chk("R4 wrap", wr_data_o, 32'h3322_1100);

        // R2 priority
        tick(1, 4'b0110, 32'h0, 0, 0, 0);
        chk("R2 ones over counting", wr_data_o, 32'hFFFF_FFFF);
        tick(1, 4'b1100, 32'h0, 0, 0, 0);
        chk("R2 counting over user", wr_data_o, 32'h3322_1100);
        tick(1, 4'b0000, 32'h0, 0, 0, 0);
        chk("R2 none gives zeros", wr_data_o, 32'h0);

        // R3 user mode, R8 later changes ignored
        tick(1, 4'b1000, 32'h5A5A_C3C3, 0, 0, 0);
        chk("R3 user word", wr_data_o, 32'h5A5A_C3C3);
        tick(0, 4'b0010, 32'h1234_5678, 1, 1, 32'h5A5A_C3C3);
        chk("R8 mode change ignored", wr_data_o, 32'h5A5A_C3C3);
        tick(0, 4'b0010, 32'h1234_5678, 0, 1, 32'h0000_0001);
        chk("R6 one mismatch", err_count_o, 32'd1);
        chk("R7 last captured", last_rd_o, 32'h0000_0001);

        // R8 start with beats present: beats ignored, state cleared
        tick(1, 4'b0100, 32'h0, 1, 1, 32'hDEAD_BEEF);
        chk("R8 err cleared", err_count_o, 32'h0);
        chk("R8 last cleared", last_rd_o, 32'h0);
        chk("R8 sequence restarted", wr_data_o, 32'h3322_1100);

        // R9 saturation on the narrow instance
        for (int i = 0; i < 20; i++) tick(0, 4'b0, 32'h0, 0, 1, 32'h0BAD_0BAD);
        chk("R9 saturated", {28'h0, err_s}, 32'hF);

        // constrained random passes
        for (int pass = 0; pass < 40; pass++) begin
            logic [3:0]  md;
            logic [31:0] uw;
            md = 4'($urandom_range(0, 15));
            uw = $urandom();
            tick(1, md, uw, 0, 0, 0);
            for (int c = 0; c < 200; c++) begin
                bit wb, rv;
                wb = ($urandom_range(0, 3) != 0);
                rv = ($urandom_range(0, 2) != 0);
                exp_rd = model_word(m_mode, m_user, m_rpos);
                if ($urandom_range(0, 19) == 0) exp_rd = exp_rd ^ (32'h1 << $urandom_range(0, 31));
                tick(0, 4'($urandom_range(0, 15)), $urandom(), wb, rv, exp_rd);
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule